// File: doc/BRIEF.md
# Serial Bus Pause Gate

This block sits in front of a serial-bus slave and lets the bus master suspend a transfer part-way through, then pick it up again without restarting the sequence. It watches the chip select, serial clock and an active-low pause request. All three are sampled by a faster system clock through synchronizers. From them it produces qualified serial-clock edge strobes for the slave's shift logic, a paused flag, and an output-drive enable for the slave's data-out pin. Shift registers and command decoding stay in the attached slave.

The pause request is qualified by the serial clock level. If the request arrives while the clock is low, the pause takes effect at once. If it arrives while the clock is high, the pause waits for the next falling clock edge. The pause is only released once the request is gone and the clock is low. The data-out pin is released as soon as the request is seen, whatever the qualification. While paused, clock edges do not reach the slave, so its bit position is held. Deselecting the slave clears the pause along with the rest of the transfer state. A small bit-position counter, cleared on deselect, shows at the ports where the transfer stands.

Top module: `hold_gate`

## Requirements
- R1: After reset, `paused`, `soEn`, both edge strobes and `bitPos` are all 0.
- R2: While selected and not paused, each rising serial-clock edge advances `bitPos` by one, wrapping from 2^POS_W-1 to 0. Rising and falling edges are passed on `sckRiseEn` and `sckFallEn`.
- R3: If the pause request (holdN = 0) is seen while the serial clock is low, `paused` goes to 1. While paused, no edge strobes are passed and `bitPos` does not change.
- R4: If the pause request is seen while the serial clock is high, `paused` stays 0 until the next falling serial-clock edge. At that edge `paused` goes to 1.
- R5: A paused transfer resumes only when holdN = 1 and the serial clock is low. holdN returning to 1 while the clock is high keeps `paused` at 1.
- R6: `soEn` is 0 whenever the synchronized holdN is 0, including in the window where the pause itself is deferred. `soEn` is 1 only while selected, holdN is 1 and not paused.
- R7: After resuming, the next rising edge advances `bitPos` from the value it held when the pause began.
- R8: Chip select going high (csN = 1) clears `paused` and `bitPos` and forces `soEn` to 0.
- R9: If holdN drops and returns to 1 while the serial clock stays high, no pause occurs and the transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial signals |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| holdN | input | 1 | Active-low pause request, asynchronous |
| sckRiseEn | output | 1 | One-cycle strobe: qualified rising serial-clock edge |
| sckFallEn | output | 1 | One-cycle strobe: qualified falling serial-clock edge |
| paused | output | 1 | Transfer is paused; the slave's shift logic is frozen |
| soEn | output | 1 | Drive enable for the slave's data-out pin (0 = high impedance) |
| bitPos | output | POS_W | Bit position in the current transfer |

## Verification
On every cycle the assertions check four things. No edge strobe passes while paused, and the bit position holds through a pause. A pause can only start or end with the serial clock low, unless a deselect ends it. Deselect clears the pause and the position. Only the bench scenarios can show the full orderings: the deferred entry waiting for a falling edge, a release with the clock high being ignored, a request cancelled before it took effect, the drive enable dropping ahead of a deferred pause, and the position carrying on after resume and wrapping.

// File: rtl/holdpause_pkg.sv
package holdpause_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,   // deselected
    ST_RUN,    // transfer active
    ST_DEFER,  // pause requested with clock high, waiting for fall
    ST_HELD    // paused
  } holdState_e;

  typedef struct packed {
    logic enterPause;
    logic leavePause;
    logic clearXfer;
    logic passRise;
    logic passFall;
  } ctrlStrobe_t;

endpackage

// File: rtl/hold_control.sv
module hold_control
  import holdpause_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csS,
  input  logic        sckS,
  input  logic        holdS,
  input  logic        sckRise,
  input  logic        sckFall,
  output ctrlStrobe_t strobe
);

  holdState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (csS) begin
      stateNext        = ST_IDLE;
      strobe.clearXfer = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_RUN;
        ST_RUN: begin
          strobe.passRise = sckRise;
          strobe.passFall = sckFall;
          if (!holdS) begin
            if (!sckS) begin
              strobe.enterPause = 1'b1;
              strobe.passFall   = 1'b0;
              stateNext         = ST_HELD;
            end else begin
              stateNext = ST_DEFER;
            end
          end
        end
        ST_DEFER: begin
          if (holdS) begin
            strobe.passFall = sckFall;
            stateNext       = ST_RUN;
          end else if (sckFall) begin
            strobe.enterPause = 1'b1;
            stateNext         = ST_HELD;
          end
        end
        ST_HELD: begin
          if (holdS && !sckS) begin
            strobe.leavePause = 1'b1;
            stateNext         = ST_RUN;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hold_datapath.sv
module hold_datapath
  import holdpause_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csNIn,
  input  logic             sckIn,
  input  logic             holdNIn,
  input  ctrlStrobe_t      strobe,
  output logic             csS,
  output logic             sckS,
  output logic             holdS,
  output logic             sckRise,
  output logic             sckFall,
  output logic             sckRiseEn,
  output logic             sckFallEn,
  output logic             paused,
  output logic             soEn,
  output logic [POS_W-1:0] bitPos
);

  localparam int          NUM_IN  = 3;
  localparam logic [2:0]  RST_VAL = 3'b101;  // holdN=1, sck=0, csN=1

  logic [NUM_IN-1:0]      rawIn;
  logic [SYNC_STAGES-1:0] syncQ [NUM_IN];
  logic                   sckPrev;

  assign rawIn = {holdNIn, sckIn, csNIn};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= {SYNC_STAGES{RST_VAL[g]}};
      else       syncQ[g] <= {syncQ[g][SYNC_STAGES-2:0], rawIn[g]};
    end
  end

  assign csS   = syncQ[0][SYNC_STAGES-1];
  assign sckS  = syncQ[1][SYNC_STAGES-1];
  assign holdS = syncQ[2][SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sckRise   = sckS & ~sckPrev;
  assign sckFall   = ~sckS & sckPrev;
  assign sckRiseEn = sckRise & strobe.passRise;
  assign sckFallEn = sckFall & strobe.passFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  paused <= 1'b0;
    else if (strobe.clearXfer)  paused <= 1'b0;
    else if (strobe.enterPause) paused <= 1'b1;
    else if (strobe.leavePause) paused <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bitPos <= '0;
    else if (strobe.clearXfer) bitPos <= '0;
    else if (sckRiseEn)        bitPos <= bitPos + 1'b1;
  end

  assign soEn = ~csS & holdS & ~paused;

  // R3: the slave sees no clock edges during a pause
  a_r3_no_edges_paused: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> (!sckRiseEn && !sckFallEn));

  // R7: the bit position survives a pause untouched
  a_r7_pos_held: assert property (@(posedge clk) disable iff (!rstN)
    (paused && $past(paused)) |-> $stable(bitPos));

  // R4: a pause only takes effect with the clock low
  a_r4_enter_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> !$past(sckS));

  // R5: a pause ends only on deselect or on a release with the clock low
  a_r5_exit_qualified: assert property (@(posedge clk) disable iff (!rstN)
    $fell(paused) |-> ($past(csS) || ($past(holdS) && !$past(sckS))));

  // R8: deselect clears the transfer state
  a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (!paused && bitPos == '0));

  // R2: the position only steps by one or restarts
  a_r2_pos_step: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos != $past(bitPos)) |-> (bitPos == $past(bitPos) + 1'b1 || bitPos == '0));

endmodule

// File: rtl/hold_gate.sv
module hold_gate
  import holdpause_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sck,
  input  logic             holdN,
  output logic             sckRiseEn,
  output logic             sckFallEn,
  output logic             paused,
  output logic             soEn,
  output logic [POS_W-1:0] bitPos
);

  ctrlStrobe_t strobe;
  logic csS, sckS, holdS, sckRise, sckFall;

  hold_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csS     (csS),
    .sckS    (sckS),
    .holdS   (holdS),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .strobe  (strobe)
  );

  hold_datapath #(.SYNC_STAGES(SYNC_STAGES), .POS_W(POS_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .csNIn     (csN),
    .sckIn     (sck),
    .holdNIn   (holdN),
    .strobe    (strobe),
    .csS       (csS),
    .sckS      (sckS),
    .holdS     (holdS),
    .sckRise   (sckRise),
    .sckFall   (sckFall),
    .sckRiseEn (sckRiseEn),
    .sckFallEn (sckFallEn),
    .paused    (paused),
    .soEn      (soEn),
    .bitPos    (bitPos)
  );

endmodule

// File: tb/hold_gate_bench.sv
module hold_gate_bench;

  localparam int POS_W = 3;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, holdN = 1'b1;
  logic sckRiseEn, sckFallEn, paused, soEn;
  logic [POS_W-1:0] bitPos;

  always #10 clk = ~clk;

  hold_gate #(.POS_W(POS_W)) u_hold_gate (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN),
    .sckRiseEn(sckRiseEn), .sckFallEn(sckFallEn), .paused(paused),
    .soEn(soEn), .bitPos(bitPos)
  );

  typedef struct {
    string req;
    bit    expPaused;
    bit    expOe;
    int    expPos;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  int expPos = 0;
  bit finished = 0;

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        testsRun++;
        if (paused !== it.expPaused || soEn !== it.expOe ||
            bitPos !== it.expPos[POS_W-1:0]) begin
          testsFailed++;
          $display("FAIL %s: paused=%0b soEn=%0b bitPos=%0d, expected paused=%0b soEn=%0b bitPos=%0d",
                   it.req, paused, soEn, bitPos, it.expPaused, it.expOe,
                   it.expPos % (1 << POS_W));
        end
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectNow(input string req, input bit p, input bit oe);
    expItem_t it;
    it.req = req; it.expPaused = p; it.expOe = oe; it.expPos = expPos;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic setSck(input bit v, input bit counts);
    sck = v;
    if (v && counts) expPos++;
    waitClk(SETTLE);
  endtask

  task automatic pulse(input bit counts);
    setSck(1'b1, counts);
    setSck(1'b0, counts);
  endtask

  initial begin
    waitClk(3);
    testsRun++;
    if (sckRiseEn !== 1'b0 || sckFallEn !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1: strobes rise=%0b fall=%0b, expected 0 0", sckRiseEn, sckFallEn);
    end
    expectNow("R1 reset state", 1'b0, 1'b0);
    rstN = 1'b1;
    waitClk(2);

    csN = 1'b0; waitClk(SETTLE);
    expectNow("R8 selected idle", 1'b0, 1'b1);
    pulse(1); pulse(1); pulse(1);
    expectNow("R2 three rising edges", 1'b0, 1'b1);

    // R3: pause requested with clock low
    holdN = 1'b0; waitClk(SETTLE);
    expectNow("R3 pause entry with sck low", 1'b1, 1'b0);
    pulse(0); pulse(0);
    expectNow("R3 edges ignored while paused", 1'b1, 1'b0);

    // R5: release with clock high is not honoured
    setSck(1'b1, 0);
    holdN = 1'b1; waitClk(SETTLE);
    expectNow("R5 release with sck high stays paused", 1'b1, 1'b0);
    setSck(1'b0, 0);
    expectNow("R5 resume once sck low", 1'b0, 1'b1);

    // R7: continues from held position
    pulse(1); pulse(1);
    expectNow("R7 position continues after resume", 1'b0, 1'b1);

    // R4 / R6: request with clock high is deferred
    setSck(1'b1, 1);
    holdN = 1'b0; waitClk(SETTLE);
    expectNow("R4 deferred pause not yet active", 1'b0, 1'b0);
    expectNow("R6 output released during deferral", 1'b0, 1'b0);
    setSck(1'b0, 0);
    expectNow("R4 pause at falling edge", 1'b1, 1'b0);
    holdN = 1'b1; waitClk(SETTLE);
    expectNow("R5 resume with sck low", 1'b0, 1'b1);
    pulse(1);
    expectNow("R2 position at top", 1'b0, 1'b1);
    pulse(1);
    expectNow("R2 position wraps to zero", 1'b0, 1'b1);

    // R9: request withdrawn before the falling edge
    setSck(1'b1, 1);
    holdN = 1'b0; waitClk(SETTLE);
    holdN = 1'b1; waitClk(SETTLE);
    expectNow("R9 cancelled request keeps output on", 1'b0, 1'b1);
    setSck(1'b0, 0);
    expectNow("R9 no pause after cancelled request", 1'b0, 1'b1);

    // R8: deselect during pause clears state
    holdN = 1'b0; waitClk(SETTLE);
    expectNow("R8 paused before deselect", 1'b1, 1'b0);
    csN = 1'b1; expPos = 0; waitClk(SETTLE);
    expectNow("R8 deselect clears pause and position", 1'b0, 1'b0);
    holdN = 1'b1; csN = 1'b0; waitClk(SETTLE);
    expectNow("R8 reselect starts clean", 1'b0, 1'b1);
    pulse(1);
    expectNow("R2 first edge after reselect", 1'b0, 1'b1);

    waitClk(2);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule